// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a few recent page mappings close to the core. Each slot holds a virtual page number as its tag, the physical frame number for that page, a write-permission flag and its own occupied flag. A lookup compares the requested virtual page against every slot at once, with no clock in the path. A match returns the physical address, formed from the stored frame number and the unchanged page offset. A lookup that matches nothing raises a miss, so an external walker can fetch the mapping from the page table and write it back through the fill port.

Fills take effect on the next clock edge. A fill goes into the lowest-numbered empty slot. When every slot is occupied, a round-robin pointer names the victim. A fill whose tag is already present updates that slot in place. Fills marked non-resident are dropped. A write lookup that matches a slot without write permission reports a protection fault in place of a hit. A flush empties the whole structure in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, so any lookup reports miss, with hit and wr_fault low.
- R2: A lookup that matches an occupied slot raises hit, and phys_addr equals the slot's frame number in the upper PFN_W bits, concatenated with lk_off in the low OFF_W bits.
- R3: A lookup that matches no occupied slot raises miss. At most one of hit, miss and wr_fault is high at any time, and all three are low while lk_req is low.
- R4: A fill with fill_resident equal to 0 changes no slot: the previous lookup results are unchanged afterwards.
- R5: While an empty slot exists, a fill of a new tag takes the lowest-numbered empty slot and evicts nothing.
- R6: When all slots are occupied, a fill of a new tag replaces the slot named by a round-robin pointer. The pointer starts at slot 0, advances by one after each replacing fill, and wraps from ENTRIES-1 to 0.
- R7: A write lookup (lk_write=1) that matches a slot whose write flag is 0 raises wr_fault and keeps hit low. A read lookup of the same page hits, and a write lookup of a writable page hits.
- R8: A fill whose tag matches an occupied slot overwrites that slot's frame number and flag. It uses no other slot and does not advance the round-robin pointer.
- R9: flush empties every slot and returns the round-robin pointer to slot 0 at the next edge. A fill in the same cycle as a flush is dropped.
- R10: A fill becomes visible to lookups only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty all slots |
| lk_req | input | 1 | A lookup is presented |
| lk_write | input | 1 | The lookup is a write access |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset carried through |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No occupied slot matches |
| wr_fault | output | 1 | Write to a page without write permission |
| phys_addr | output | PFN_W+OFF_W | Translated address, zero when hit is low |
| fill_en | input | 1 | Install a mapping at the next edge |
| fill_resident | input | 1 | The mapping is resident; fills with 0 are dropped |
| fill_writable | input | 1 | Write permission of the mapping |
| fill_vpn | input | VPN_W | Tag of the mapping |
| fill_pfn | input | PFN_W | Frame number of the mapping |

## Verification
The bench first fills every slot. It then checks that the ninth and tenth fills evict the first and second pages, and that after a full lap the pointer wraps back to slot 0. A design that evicted early, or never wrapped, would lose the wrong page. A refill of a present tag while the structure is full must leave the pointer where it was. A design that allocated a second copy, or advanced the pointer, would evict the wrong page on the next fill. Other cases covered: a write to a read-only page must fault without a hit, a non-resident fill must leave no trace, a flush raised together with a fill must win, and a fill must stay invisible until its capturing edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_HIT    = 2'd1,
    LK_MISS   = 2'd2,
    LK_WFAULT = 2'd3
  } lk_res_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid,
  input  logic [VPN_W-1:0] tags [N],
  input  logic [VPN_W-1:0] key,
  output logic             any,
  output logic [IW-1:0]    idx
);
  logic [N-1:0] eq_vec;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign eq_vec[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any = |eq_vec;
  assign idx = lowest_set(eq_vec);
endmodule

// File: rtl/xlat_alloc.sv
module xlat_alloc #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [N-1:0]  valid,
  input  logic          advance,
  output logic          free_any,
  output logic [IW-1:0] free_idx,
  output logic [IW-1:0] rr_idx
);
  logic [IW-1:0] rr_q;

  function automatic logic [IW-1:0] first_empty(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] rr_next(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + IW'(1);
  endfunction

  assign free_any = ~&valid;
  assign free_idx = first_empty(valid);
  assign rr_idx   = rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (flush)   rr_q <= '0;
    else if (advance) rr_q <= rr_next(rr_q);
  end

  // R6: a replacing fill moves the pointer by exactly one, with wrap
  a_r6_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !flush) |=> (rr_q == rr_next($past(rr_q))));
  // R8: without a replacing fill or flush the pointer holds still
  a_r8_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !flush) |=> $stable(rr_q));
  // R9: flush brings the pointer home
  a_r9_rr_home: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rr_q == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 18,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lk_req,
  input  logic                   lk_write,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   hit,
  output logic                   miss,
  output logic                   wr_fault,
  output logic [PFN_W+OFF_W-1:0] phys_addr,
  input  logic                   fill_en,
  input  logic                   fill_resident,
  input  logic                   fill_writable,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PA_W = PFN_W + OFF_W;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] wr_ok_q;

  // named internal events
  logic          lk_any, dup_any, free_any, fill_go, replace_ev;
  logic [IW-1:0] lk_idx, dup_idx, free_idx, rr_idx, fill_slot;
  lk_res_e       lk_res;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .key(lk_vpn), .any(lk_any), .idx(lk_idx)
  );

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_dup_match (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn), .any(dup_any), .idx(dup_idx)
  );

  xlat_alloc #(.N(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .flush(flush), .valid(valid_q),
    .advance(replace_ev), .free_any(free_any), .free_idx(free_idx), .rr_idx(rr_idx)
  );

  function automatic lk_res_e classify(input logic req, input logic found,
                                       input logic is_wr, input logic perm);
    if (!req)                 return LK_IDLE;
    if (!found)               return LK_MISS;
    if (is_wr && !perm)       return LK_WFAULT;
    return LK_HIT;
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PFN_W-1:0] f,
                                               input logic [OFF_W-1:0] o);
    return {f, o};
  endfunction

  assign lk_res    = classify(lk_req, lk_any, lk_write, wr_ok_q[lk_idx]);
  assign hit       = (lk_res == LK_HIT);
  assign miss      = (lk_res == LK_MISS);
  assign wr_fault  = (lk_res == LK_WFAULT);
  assign phys_addr = hit ? join_addr(pfn_q[lk_idx], lk_off) : '0;

  assign fill_go    = fill_en && fill_resident && !flush;
  assign replace_ev = fill_go && !dup_any && !free_any;
  assign fill_slot  = dup_any ? dup_idx : (free_any ? free_idx : rr_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill_go) begin
      valid_q[fill_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fill_slot]   <= fill_vpn;
      pfn_q[fill_slot]   <= fill_pfn;
      wr_ok_q[fill_slot] <= fill_writable;
    end
  end

  // R3: result flags never overlap
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, wr_fault}));
  // R3: idle lookup drives no flag
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !(hit || miss || wr_fault));
  // R4: non-resident fill leaves the occupancy alone
  a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_resident && !flush) |=> $stable(valid_q));
  // R8: refilling a present tag does not add occupancy
  a_r8_inplace: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && dup_any) |=> ($countones(valid_q) == $countones($past(valid_q))));
  // R9: flush empties everything
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  // R5: a new tag while space remains takes one more slot
  a_r5_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !dup_any && free_any) |=>
      ($countones(valid_q) == $countones($past(valid_q)) + 1));
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int VPN_W = 20, PFN_W = 18, OFF_W = 12;

  logic clk = 0, rst_n = 0, flush = 0;
  logic lk_req = 0, lk_write = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [OFF_W-1:0] lk_off = '0;
  logic hit, miss, wr_fault;
  logic [PFN_W+OFF_W-1:0] phys_addr;
  logic fill_en = 0, fill_resident = 0, fill_writable = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_req(lk_req), .lk_write(lk_write),
    .lk_vpn(lk_vpn), .lk_off(lk_off), .hit(hit), .miss(miss), .wr_fault(wr_fault),
    .phys_addr(phys_addr), .fill_en(fill_en), .fill_resident(fill_resident),
    .fill_writable(fill_writable), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
  );

  function automatic logic [PFN_W-1:0] frame_of(input int v);
    return PFN_W'(v * 7 + 3);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int v, input logic [PFN_W-1:0] f, input logic res, input logic wr);
    @(negedge clk);
    fill_en = 1; fill_vpn = VPN_W'(v); fill_pfn = f; fill_resident = res; fill_writable = wr;
    @(posedge clk); #1;
    fill_en = 0; fill_resident = 0;
  endtask

  // returns {wr_fault, miss, hit}
  task automatic look(input int v, input logic [OFF_W-1:0] o, input logic wr,
                      output logic [2:0] flags, output logic [PFN_W+OFF_W-1:0] pa);
    @(negedge clk);
    lk_req = 1; lk_vpn = VPN_W'(v); lk_off = o; lk_write = wr;
    #1;
    flags = {wr_fault, miss, hit}; pa = phys_addr;
    lk_req = 0; lk_write = 0;
  endtask

  task automatic expect_hit(input string req, input int v, input logic [PFN_W-1:0] f);
    logic [2:0] fl; logic [PFN_W+OFF_W-1:0] pa;
    look(v, OFF_W'(v * 13 + 1), 0, fl, pa);
    chk(req, {61'd0, fl}, 64'd1);
    chk(req, 64'(pa), 64'({f, OFF_W'(v * 13 + 1)}));
  endtask

  task automatic expect_miss(input string req, input int v);
    logic [2:0] fl; logic [PFN_W+OFF_W-1:0] pa;
    look(v, 0, 0, fl, pa);
    chk(req, {61'd0, fl}, 64'd2);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1; flush = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3 idle", {61'd0, wr_fault, miss, hit}, 64'd0);
    expect_miss("R1", 5);
    expect_miss("R1", 0);
  endtask

  task automatic t_timing_and_hit();
    @(negedge clk);
    fill_en = 1; fill_resident = 1; fill_writable = 1; fill_vpn = 20'h00abc; fill_pfn = 18'h2f0f0;
    lk_req = 1; lk_vpn = 20'h00abc; lk_off = 12'hfff; #1;
    chk("R10 before edge", {63'd0, miss}, 64'd1);
    @(posedge clk); #1;
    fill_en = 0; fill_resident = 0;
    chk("R10 after edge", {63'd0, hit}, 64'd1);
    chk("R2 addr", 64'(phys_addr), 64'({18'h2f0f0, 12'hfff}));
    lk_req = 0;
    do_flush();
  endtask

  task automatic t_reject();
    fill(40, frame_of(40), 0, 1);
    expect_miss("R4 rejected fill", 40);
    fill(41, frame_of(41), 1, 1);
    fill(41, 18'h11111, 0, 1);
    expect_hit("R4 old mapping kept", 41, frame_of(41));
    do_flush();
  endtask

  task automatic t_perm();
    logic [2:0] fl; logic [PFN_W+OFF_W-1:0] pa;
    fill(60, frame_of(60), 1, 0);
    fill(61, frame_of(61), 1, 1);
    look(60, 12'h010, 1, fl, pa);
    chk("R7 write to read-only", {61'd0, fl}, 64'd4);
    expect_hit("R7 read of read-only", 60, frame_of(60));
    look(61, 12'h020, 1, fl, pa);
    chk("R7 write to writable", {61'd0, fl}, 64'd1);
    chk("R7 write addr", 64'(pa), 64'({frame_of(61), 12'h020}));
    do_flush();
  endtask

  task automatic t_fill_and_replace();
    for (int v = 1; v <= 8; v++) fill(v, frame_of(v), 1, 1);
    for (int v = 1; v <= 8; v++) expect_hit("R5 all kept", v, frame_of(v));
    fill(9, frame_of(9), 1, 1);
    expect_miss("R6 first victim slot0", 1);
    expect_hit("R6 page2 still in", 2, frame_of(2));
    fill(10, frame_of(10), 1, 1);
    expect_miss("R6 second victim slot1", 2);
    expect_hit("R6 page3 still in", 3, frame_of(3));
    for (int v = 11; v <= 16; v++) fill(v, frame_of(v), 1, 1);
    fill(17, frame_of(17), 1, 1);
    expect_miss("R6 wrap to slot0", 9);
    expect_hit("R6 slot1 kept", 10, frame_of(10));
    expect_hit("R6 newest", 17, frame_of(17));
  endtask

  task automatic t_flush_and_dup();
    @(negedge clk);
    flush = 1; fill_en = 1; fill_resident = 1; fill_writable = 1; fill_vpn = 20'd99; fill_pfn = frame_of(99);
    @(posedge clk); #1;
    flush = 0; fill_en = 0; fill_resident = 0;
    expect_miss("R9 emptied", 17);
    expect_miss("R9 fill dropped", 99);
    for (int v = 1; v <= 8; v++) fill(v, frame_of(v), 1, 1);
    fill(3, 18'h3aaaa, 1, 1);
    expect_hit("R8 overwritten", 3, 18'h3aaaa);
    fill(9, frame_of(9), 1, 1);
    expect_miss("R9 pointer home / R8 no advance", 1);
    expect_hit("R8 slot1 kept", 2, frame_of(2));
    expect_hit("R8 dup still in", 3, 18'h3aaaa);
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_timing_and_hit();
    t_reject();
    t_perm();
    t_fill_and_replace();
    t_flush_and_dup();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule